// File: doc/BRIEF.md
# Segment Prefetch/Restore Transfer Engine

This block is the background side of a channel-buffered DRAM core. The storage array has two banks, and each bank has a small, parameterised set of rows. Every row holds four equal segments. There are sixteen channel buffers, and each buffer is exactly one segment wide. The engine keeps track of the open row in each bank. A prefetch copies one segment of the open row into a chosen channel. A restore copies a chosen channel back into one segment of a row. The engine also serves a simple foreground port that reads or writes a whole channel.

Commands arrive on a valid/ready stream. The engine deasserts `cmd_ready` while a segment copy or a prefetch-read result is still in flight, and the command on the port is held until it is accepted. The foreground port is also valid/ready. It stalls only for the channel that is currently being filled, and it stalls for every channel while a prefetch read waits to deliver its data. Read results come back on `rd_valid`/`rd_data`, which have no back-pressure: the consumer must take each result in the cycle it appears. A restore works in two steps. The restore command first names the channel and the segment. The next activate to that bank then supplies the row, and the array write happens at that activate.

Top module: `segxfer_engine`

## Requirements
- R1: After reset, both banks are closed. `cmd_ready` and `fg_ready` are 1, `rd_valid` and `err_o` are 0, and every channel and array word reads as zero.
- R2: An activate (op 1) to a closed bank opens the addressed row. An activate to an open bank is illegal: `err_o` is 1 in the cycle after acceptance and the open row stays unchanged.
- R3: A prefetch (op 2) to an open bank loads the channel with the addressed segment of the open row. The new value is visible exactly XFER_CYCLES cycles after acceptance. Throughout that window `cmd_ready` is 0 and foreground access to the target channel is stalled, while other channels stay accessible.
- R4: A prefetch or prefetch read to a closed bank raises `err_o` for one cycle. It leaves every channel unchanged and does not deassert `cmd_ready`.
- R5: Field positions in `cmd_addr` are fixed. The bank is bit 13 and auto-precharge is bit 10. The segment is bits 1:0. The channel number is {bit 12, bit 11, bit 9, bit 8}, most significant first. The row for an activate is the low log2(ROWS) bits. Bits 7:2 are ignored for prefetch commands.
- R6: A restore (op 3) to a closed bank records its channel and segment. The next activate to that bank writes that channel's current contents into the named segment of the row the activate supplies.
- R7: With bit 10 set, a prefetch closes its bank when it is accepted. A restore with bit 10 set leaves the bank closed after the activate that performs its write.
- R8: A prefetch read (op 6) acts like a prefetch and also delivers the segment on `rd_valid`/`rd_data` exactly PFR_LAT cycles after acceptance. Until then `fg_ready` is 0.
- R9: A precharge (op 4) closes the addressed bank. A precharge-all (op 5) closes both banks.
- R10: An accepted foreground write updates the channel. An accepted foreground read returns the channel on `rd_valid`/`rd_data` in the next cycle, and `rd_valid` lasts one cycle per result.
- R11: A restore to an open bank raises `err_o` and records nothing. A following activate to the closed bank therefore writes nothing into the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine can accept a command |
| cmd_op | input | 3 | 0 none, 1 activate, 2 prefetch, 3 restore, 4 precharge, 5 precharge-all, 6 prefetch read |
| cmd_addr | input | 14 | Bank, row, channel, segment and auto-precharge fields |
| fg_valid | input | 1 | Foreground access offered |
| fg_ready | output | 1 | Foreground access can be accepted |
| fg_write | input | 1 | 1 write, 0 read |
| fg_ch | input | 4 | Foreground channel number |
| fg_wdata | input | SEG_W | Foreground write data |
| rd_valid | output | 1 | Read result valid (one cycle) |
| rd_data | output | SEG_W | Read result |
| err_o | output | 1 | Previous accepted command was illegal |

## Verification
The assertions assume that `cmd_op` and `cmd_addr` stay stable while `cmd_valid` waits for `cmd_ready`. They also assume that the consumer of `rd_valid` never needs to hold a result. The stimulus follows both rules. Every command task holds its fields until the handshake completes, and the bench samples each result in the cycle it appears. Illegal commands are issued on purpose only where a requirement names them. Every other command in the stimulus is issued to a bank whose open or closed state the bench already knows.

// File: rtl/segxfer_pkg.sv
package segxfer_pkg;
  localparam int ADDR_W    = 14;
  localparam int NUM_BANKS = 2;
  localparam int NUM_CH    = 16;
  localparam int CH_IDX_W  = 4;
  localparam int SEG_IDX_W = 2;
  localparam int BANK_BIT  = 13;
  localparam int AP_BIT    = 10;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_ACT  = 3'd1,
    OP_PFC  = 3'd2,
    OP_RST  = 3'd3,
    OP_PRE  = 3'd4,
    OP_PALL = 3'd5,
    OP_PFR  = 3'd6,
    OP_BAD  = 3'd7
  } seg_op_e;

  typedef struct packed {
    logic                 bank;
    logic                 ap;
    logic [CH_IDX_W-1:0]  ch;
    logic [SEG_IDX_W-1:0] seg;
  } seg_cmd_t;
endpackage

// File: rtl/segxfer_decode.sv
module segxfer_decode
  import segxfer_pkg::*;
#(
  parameter int ROW_W = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output seg_cmd_t          cmd,
  output logic [ROW_W-1:0]  row
);
  logic unused_addr_bits;

  always_comb begin
    cmd.bank = addr[BANK_BIT];
    cmd.ap   = addr[AP_BIT];
    cmd.ch   = {addr[12], addr[11], addr[9], addr[8]};
    cmd.seg  = addr[SEG_IDX_W-1:0];
    row      = addr[ROW_W-1:0];
  end

  assign unused_addr_bits = ^addr[7:2];
endmodule

// File: rtl/segxfer_banks.sv
module segxfer_banks
  import segxfer_pkg::*;
#(
  parameter int ROW_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  seg_op_e              op,
  input  seg_cmd_t             cmd,
  input  logic [ROW_W-1:0]     row,
  output logic [NUM_BANKS-1:0] open_o,
  output logic [ROW_W-1:0]     cur_row_o,
  output logic                 pf_start_o,
  output logic                 wb_en_o,
  output logic [CH_IDX_W-1:0]  wb_ch_o,
  output logic [SEG_IDX_W-1:0] wb_seg_o,
  output logic                 err_o
);
  logic [NUM_BANKS-1:0] open_q;
  logic [ROW_W-1:0]     row_q    [NUM_BANKS];
  logic [NUM_BANKS-1:0] pend_v;
  logic [NUM_BANKS-1:0] pend_ap;
  logic [CH_IDX_W-1:0]  pend_ch  [NUM_BANKS];
  logic [SEG_IDX_W-1:0] pend_seg [NUM_BANKS];
  logic                 err_q;
  logic                 is_open, is_pf, bad, act_ok;

  always_comb begin
    is_open    = open_q[cmd.bank];
    is_pf      = (op == OP_PFC) || (op == OP_PFR);
    bad        = ((op == OP_ACT) && is_open) || (is_pf && !is_open) ||
                 ((op == OP_RST) && is_open) || (op == OP_BAD);
    act_ok     = accept && (op == OP_ACT) && !is_open;
    pf_start_o = accept && is_pf && is_open;
    wb_en_o    = act_ok && pend_v[cmd.bank];
    wb_ch_o    = pend_ch[cmd.bank];
    wb_seg_o   = pend_seg[cmd.bank];
    cur_row_o  = row_q[cmd.bank];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q  <= '0;
      pend_v  <= '0;
      pend_ap <= '0;
      err_q   <= 1'b0;
      for (int b = 0; b < NUM_BANKS; b++) begin
        row_q[b]    <= '0;
        pend_ch[b]  <= '0;
        pend_seg[b] <= '0;
      end
    end else begin
      err_q <= accept && bad;
      if (accept) begin
        unique case (op)
          OP_ACT: if (!is_open) begin
            open_q[cmd.bank] <= !(pend_v[cmd.bank] && pend_ap[cmd.bank]);
            row_q[cmd.bank]  <= row;
            pend_v[cmd.bank] <= 1'b0;
          end
          OP_PFC, OP_PFR: if (is_open && cmd.ap) open_q[cmd.bank] <= 1'b0;
          OP_RST: if (!is_open) begin
            pend_v[cmd.bank]   <= 1'b1;
            pend_ap[cmd.bank]  <= cmd.ap;
            pend_ch[cmd.bank]  <= cmd.ch;
            pend_seg[cmd.bank] <= cmd.seg;
          end
          OP_PRE:  open_q[cmd.bank] <= 1'b0;
          OP_PALL: open_q <= '0;
          default: ;
        endcase
      end
    end
  end

  assign open_o = open_q;
  assign err_o  = err_q;
endmodule

// File: rtl/segxfer_xfer.sv
module segxfer_xfer
  import segxfer_pkg::*;
#(
  parameter int XFER_CYCLES = 3,
  parameter int PFR_LAT     = 4,
  parameter int SEG_W       = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                start_pfr,
  input  logic [CH_IDX_W-1:0] start_ch,
  input  logic [SEG_W-1:0]    start_data,
  output logic                busy_o,
  output logic [CH_IDX_W-1:0] busy_ch_o,
  output logic                done_o,
  output logic [SEG_W-1:0]    data_o,
  output logic                pfr_pend_o,
  output logic                pfr_fire_o
);
  localparam int XW = $clog2(XFER_CYCLES + 1);
  localparam int PW = $clog2(PFR_LAT + 1);

  logic [XW-1:0]       xc;
  logic [PW-1:0]       pc;
  logic [CH_IDX_W-1:0] ch_q;
  logic [SEG_W-1:0]    data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xc     <= '0;
      pc     <= '0;
      ch_q   <= '0;
      data_q <= '0;
    end else if (start) begin
      xc     <= XW'(XFER_CYCLES);
      pc     <= start_pfr ? PW'(PFR_LAT) : '0;
      ch_q   <= start_ch;
      data_q <= start_data;
    end else begin
      if (xc != '0) xc <= xc - XW'(1);
      if (pc != '0) pc <= pc - PW'(1);
    end
  end

  assign busy_o     = (xc != '0);
  assign busy_ch_o  = ch_q;
  assign done_o     = (xc == XW'(1));
  assign data_o     = data_q;
  assign pfr_pend_o = (pc != '0);
  assign pfr_fire_o = (pc == PW'(1));
endmodule

// File: rtl/segxfer_chans.sv
module segxfer_chans
  import segxfer_pkg::*;
#(
  parameter int SEG_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                a_we,
  input  logic [CH_IDX_W-1:0] a_ch,
  input  logic [SEG_W-1:0]    a_d,
  input  logic                b_we,
  input  logic [CH_IDX_W-1:0] b_ch,
  input  logic [SEG_W-1:0]    b_d,
  input  logic [CH_IDX_W-1:0] r0_ch,
  output logic [SEG_W-1:0]    r0_d,
  input  logic [CH_IDX_W-1:0] r1_ch,
  output logic [SEG_W-1:0]    r1_d
);
  logic [SEG_W-1:0] vals [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [SEG_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                  q <= '0;
      else if (a_we && (a_ch == CH_IDX_W'(i)))     q <= a_d;
      else if (b_we && (b_ch == CH_IDX_W'(i)))     q <= b_d;
    end
    assign vals[i] = q;
  end

  assign r0_d = vals[r0_ch];
  assign r1_d = vals[r1_ch];
endmodule

// File: rtl/segxfer_array.sv
module segxfer_array #(
  parameter int IDX_W = 5,
  parameter int SEG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [SEG_W-1:0] wd,
  input  logic [IDX_W-1:0] ridx,
  output logic [SEG_W-1:0] rd
);
  localparam int DEPTH = 1 << IDX_W;

  logic [SEG_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wd;
    end
  end

  assign rd = mem[ridx];
endmodule

// File: rtl/segxfer_engine.sv
module segxfer_engine
  import segxfer_pkg::*;
#(
  parameter int ROWS        = 4,
  parameter int SEG_W       = 32,
  parameter int XFER_CYCLES = 3,
  parameter int PFR_LAT     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              fg_valid,
  output logic              fg_ready,
  input  logic              fg_write,
  input  logic [3:0]        fg_ch,
  input  logic [SEG_W-1:0]  fg_wdata,
  output logic              rd_valid,
  output logic [SEG_W-1:0]  rd_data,
  output logic              err_o
);
  localparam int ROW_W = $clog2(ROWS);
  localparam int IDX_W = 1 + ROW_W + SEG_IDX_W;

  seg_op_e              op;
  seg_cmd_t             cmd_d;
  logic [ROW_W-1:0]     cmd_row;
  logic                 accept, fg_accept;
  logic [NUM_BANKS-1:0] bank_open;
  logic [ROW_W-1:0]     cur_row;
  logic                 pf_start, wb_en;
  logic [CH_IDX_W-1:0]  wb_ch;
  logic [SEG_IDX_W-1:0] wb_seg;
  logic                 xfer_busy, xfer_done, pfr_pend, pfr_fire;
  logic [CH_IDX_W-1:0]  xfer_ch;
  logic [SEG_W-1:0]     xfer_data, arr_rd, ch_rd_fg, ch_rd_wb;

  assign op        = seg_op_e'(cmd_op);
  assign cmd_ready = !xfer_busy && !pfr_pend;
  assign accept    = cmd_valid && cmd_ready;
  assign fg_ready  = !pfr_pend && !(xfer_busy && (xfer_ch == fg_ch));
  assign fg_accept = fg_valid && fg_ready;

  segxfer_decode #(.ROW_W(ROW_W)) u_dec (
    .addr(cmd_addr), .cmd(cmd_d), .row(cmd_row)
  );

  segxfer_banks #(.ROW_W(ROW_W)) u_banks (
    .clk(clk), .rst_n(rst_n), .accept(accept), .op(op), .cmd(cmd_d),
    .row(cmd_row), .open_o(bank_open), .cur_row_o(cur_row),
    .pf_start_o(pf_start), .wb_en_o(wb_en), .wb_ch_o(wb_ch),
    .wb_seg_o(wb_seg), .err_o(err_o)
  );

  segxfer_array #(.IDX_W(IDX_W), .SEG_W(SEG_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .we(wb_en),
    .widx({cmd_d.bank, cmd_row, wb_seg}), .wd(ch_rd_wb),
    .ridx({cmd_d.bank, cur_row, cmd_d.seg}), .rd(arr_rd)
  );

  segxfer_xfer #(.XFER_CYCLES(XFER_CYCLES), .PFR_LAT(PFR_LAT), .SEG_W(SEG_W)) u_xfer (
    .clk(clk), .rst_n(rst_n), .start(pf_start), .start_pfr(op == OP_PFR),
    .start_ch(cmd_d.ch), .start_data(arr_rd), .busy_o(xfer_busy),
    .busy_ch_o(xfer_ch), .done_o(xfer_done), .data_o(xfer_data),
    .pfr_pend_o(pfr_pend), .pfr_fire_o(pfr_fire)
  );

  segxfer_chans #(.SEG_W(SEG_W)) u_ch (
    .clk(clk), .rst_n(rst_n),
    .a_we(xfer_done), .a_ch(xfer_ch), .a_d(xfer_data),
    .b_we(fg_accept && fg_write), .b_ch(fg_ch), .b_d(fg_wdata),
    .r0_ch(fg_ch), .r0_d(ch_rd_fg), .r1_ch(wb_ch), .r1_d(ch_rd_wb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= pfr_fire || (fg_accept && !fg_write);
      rd_data  <= pfr_fire ? xfer_data : ch_rd_fg;
    end
  end
endmodule

// File: rtl/segxfer_chk.sv
module segxfer_chk
  import segxfer_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_op,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              fg_valid,
  input logic              fg_ready,
  input logic              fg_write,
  input logic              rd_valid,
  input logic              err_o,
  input logic [NUM_BANKS-1:0] bank_open
);
  logic acc, tgt_open, pf_op;
  assign acc      = cmd_valid && cmd_ready;
  assign tgt_open = bank_open[cmd_addr[BANK_BIT]];
  assign pf_op    = (cmd_op == 3'(OP_PFC)) || (cmd_op == 3'(OP_PFR));

  AST_ACT_OPEN_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (cmd_op == 3'(OP_ACT)) && tgt_open |=> err_o); // R2
  AST_PF_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (cmd_op == 3'(OP_PFC)) && tgt_open |=> !cmd_ready); // R3
  AST_PF_CLOSED_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    acc && pf_op && !tgt_open |=> err_o && cmd_ready); // R4
  AST_PFR_HOLDS_FG: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (cmd_op == 3'(OP_PFR)) && tgt_open |=> !fg_ready); // R8
  AST_PALL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (cmd_op == 3'(OP_PALL)) |=> bank_open == '0); // R9
  AST_FG_READ_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    fg_valid && fg_ready && !fg_write |=> rd_valid); // R10
  AST_RST_OPEN_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (cmd_op == 3'(OP_RST)) && tgt_open |=> err_o); // R11
endmodule

bind segxfer_engine segxfer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_addr(cmd_addr), .fg_valid(fg_valid),
  .fg_ready(fg_ready), .fg_write(fg_write), .rd_valid(rd_valid),
  .err_o(err_o), .bank_open(bank_open)
);

// File: tb/segxfer_engine_tb_top.sv
module segxfer_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = 3'd0;
  logic [13:0] cmd_addr = '0;
  logic        fg_valid = 1'b0;
  logic        fg_ready;
  logic        fg_write = 1'b0;
  logic [3:0]  fg_ch = '0;
  logic [31:0] fg_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        err_o;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #2.5 clk = ~clk;

  segxfer_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .fg_valid(fg_valid),
    .fg_ready(fg_ready), .fg_write(fg_write), .fg_ch(fg_ch),
    .fg_wdata(fg_wdata), .rd_valid(rd_valid), .rd_data(rd_data), .err_o(err_o)
  );

  localparam logic [2:0] ACT = 3'd1, PFC = 3'd2, RST = 3'd3, PRE = 3'd4,
                         PALL = 3'd5, PFR = 3'd6;

  function automatic logic [31:0] pat(int b, int r, int s);
    return {16'hC0DE, 4'(b), 4'(r), 4'(s), 4'hA};
  endfunction

  function automatic logic [13:0] xaddr(int b, int ap, int ch, int s);
    logic [3:0] c = 4'(ch);
    return {1'(b), c[3], c[2], 1'(ap), c[1], c[0], 6'b101101, 2'(s)};
  endfunction

  function automatic logic [13:0] raddr(int b, int r);
    return {1'(b), 11'b0, 2'(r)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [13:0] a);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
  endtask

  task automatic wait_idle();
    while (!cmd_ready) @(negedge clk);
  endtask

  task automatic fg_wr(input int ch, input logic [31:0] d);
    @(negedge clk);
    fg_valid = 1'b1; fg_write = 1'b1; fg_ch = 4'(ch); fg_wdata = d;
    while (!fg_ready) @(negedge clk);
    @(negedge clk);
    fg_valid = 1'b0; fg_write = 1'b0;
  endtask

  task automatic fg_rd(input int ch, input logic [31:0] exp, input string req);
    @(negedge clk);
    fg_valid = 1'b1; fg_write = 1'b0; fg_ch = 4'(ch);
    while (!fg_ready) @(negedge clk);
    @(negedge clk);
    fg_valid = 1'b0;
    chk(rd_valid && rd_data == exp, req, rd_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(cmd_ready && fg_ready && !rd_valid && !err_o, "R1 idle outputs",
        {28'b0, cmd_ready, fg_ready, rd_valid, err_o}, 32'hC);
    for (int c = 0; c < 16; c++) fg_rd(c, 32'h0, "R1 channel zero");

    // R2: activate rules
    do_cmd(ACT, raddr(0, 1));
    chk(!err_o, "R2 act closed", {31'b0, err_o}, 0);
    do_cmd(ACT, raddr(0, 2));
    chk(err_o, "R2 act open flagged", {31'b0, err_o}, 1);
    // R9: precharge closes
    do_cmd(PRE, raddr(0, 0));
    do_cmd(ACT, raddr(0, 0));
    chk(!err_o, "R9 pre closed bank", {31'b0, err_o}, 0);
    do_cmd(PRE, raddr(0, 0));

    // R4: prefetch / prefetch read to a closed bank
    fg_wr(5, 32'h1234_5678);
    do_cmd(PFC, xaddr(1, 0, 5, 0));
    chk(err_o && cmd_ready, "R4 pfc closed flagged",
        {30'b0, err_o, cmd_ready}, 3);
    do_cmd(PFR, xaddr(1, 0, 5, 0));
    chk(err_o && cmd_ready && !rd_valid, "R4 pfr closed flagged",
        {29'b0, err_o, cmd_ready, rd_valid}, 6);
    repeat (5) @(negedge clk);
    fg_rd(5, 32'h1234_5678, "R4 channel untouched");

    // R11: restore to open bank ignored
    fg_wr(3, 32'hDEAD_0003);
    do_cmd(ACT, raddr(1, 0));
    do_cmd(RST, xaddr(1, 0, 3, 2));
    chk(err_o, "R11 rst open flagged", {31'b0, err_o}, 1);
    do_cmd(PALL, 14'h0);
    do_cmd(ACT, raddr(1, 0));
    chk(!err_o, "R9 pall closed bank1", {31'b0, err_o}, 0);
    do_cmd(PFC, xaddr(1, 0, 6, 2));
    wait_idle();
    fg_rd(6, 32'h0, "R11 no array write");
    do_cmd(PALL, 14'h0);

    // R6/R7: fill the whole array through restores with auto precharge
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < 4; r++)
        for (int s = 0; s < 4; s++) begin
          fg_wr(r * 4 + s, pat(b, r, s));
          do_cmd(RST, xaddr(b, 1, r * 4 + s, s));
          chk(!err_o, "R6 rst accepted", {31'b0, err_o}, 0);
          do_cmd(ACT, raddr(b, r));
          chk(!err_o, "R7 rst-ap left bank closed", {31'b0, err_o}, 0);
        end

    // R3/R5/R6: sweep every segment back through prefetch
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < 4; r++) begin
        do_cmd(ACT, raddr(b, r));
        chk(!err_o, "R2 act for sweep", {31'b0, err_o}, 0);
        for (int s = 0; s < 4; s++) begin
          int t = (s * 5 + r + b * 3) % 16;
          do_cmd(PFC, xaddr(b, 0, t, s));
          fg_ch = 4'(t);
          #1;
          chk(!cmd_ready && !fg_ready, "R3 busy window",
              {30'b0, cmd_ready, fg_ready}, 0);
          fg_ch = 4'(t ^ 1);
          #1;
          chk(fg_ready, "R3 other channel free", {31'b0, fg_ready}, 1);
          wait_idle();
          fg_rd(t, pat(b, r, s), "R5 R6 R3 prefetched segment");
        end
        if (r % 2 == 0) do_cmd(PRE, raddr(b, 0));
        else            do_cmd(PALL, 14'h0);
      end

    // R3: exact completion cycle
    do_cmd(ACT, raddr(1, 1));
    fg_wr(12, 32'hFFFF_0000);
    do_cmd(PFC, xaddr(1, 0, 12, 3));
    fg_ch = 4'd12;
    repeat (2) @(negedge clk);
    chk(!fg_ready, "R3 still busy at cycle 2", {31'b0, fg_ready}, 0);
    @(negedge clk);
    chk(fg_ready && cmd_ready, "R3 free at cycle 3",
        {30'b0, fg_ready, cmd_ready}, 3);
    fg_rd(12, pat(1, 1, 3), "R3 value at completion");
    do_cmd(PALL, 14'h0);

    // R7: prefetch with auto precharge
    do_cmd(ACT, raddr(0, 3));
    do_cmd(PFC, xaddr(0, 1, 9, 2));
    wait_idle();
    do_cmd(ACT, raddr(0, 0));
    chk(!err_o, "R7 pfc-ap closed bank", {31'b0, err_o}, 0);
    fg_rd(9, pat(0, 3, 2), "R7 pfc-ap data");
    do_cmd(PALL, 14'h0);

    // R8: prefetch read latency
    do_cmd(ACT, raddr(1, 2));
    do_cmd(PFR, xaddr(1, 0, 4, 1));
    fg_ch = 4'd0;
    #1;
    chk(!rd_valid && !fg_ready, "R8 k0", {30'b0, rd_valid, fg_ready}, 0);
    for (int k = 1; k < 4; k++) begin
      @(negedge clk);
      chk(!rd_valid && !fg_ready, "R8 before latency",
          {30'b0, rd_valid, fg_ready}, 0);
    end
    @(negedge clk);
    chk(rd_valid && rd_data == pat(1, 2, 1), "R8 data at latency", rd_data,
        pat(1, 2, 1));
    @(negedge clk);
    chk(!rd_valid && fg_ready, "R8 released", {30'b0, rd_valid, fg_ready}, 1);
    fg_rd(4, pat(1, 2, 1), "R8 channel loaded");
    do_cmd(PALL, 14'h0);

    // R10: foreground write/read and single-cycle result
    fg_wr(7, 32'h0BAD_F00D);
    fg_rd(7, 32'h0BAD_F00D, "R10 write then read");
    @(negedge clk);
    chk(!rd_valid, "R10 one-cycle result", {31'b0, rd_valid}, 0);

    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule